// File: doc/BRIEF.md
# Open-Switch Fault Cell Locator

This block is the decision stage of a fault monitor for a converter built from a chain of bridge cells. It works on the output of a mismatch detector. That detector supplies three flags: a positive error, a negative error, and an error-cleared flag. The block also takes, for each cell, one bit that says the cell has recently been commanded to step its voltage up and one bit that says it has been commanded to step down. All state changes happen only on clock edges where the sample enable is high.

After a positive or a negative error is seen, the block declares a fault. It then waits for the error to disappear. Once the error has cleared, it names the faulty cell: this is the single cell whose recent step command points against the polarity of the error. The result stays latched until reset. It is given both as a one-hot vector and as a 1-based cell number. If the step indicators do not single out exactly one cell, the block raises an ambiguity flag and goes back to waiting.

Top module: `fault_cell_locator`

## Requirements
- R1: From idle, a sampled positive error enters the positive-fault wait, and a sampled negative error enters the negative-fault wait. Both assert `fault_any` and leave the location outputs at zero.
- R2: In a fault wait, the block takes no decision until `err_clear` is sampled. That sample moves it into the decision state that matches its polarity. Location outputs stay zero until the decision.
- R3: When `err_pos` and `err_neg` are both sampled in idle, the positive branch is taken.
- R4: In the positive decision state, exactly one high bit of `step_dn` locates the fault at that cell. `step_up` is ignored there.
- R5: In the negative decision state, exactly one high bit of `step_up` locates the fault at that cell. `step_dn` is ignored there.
- R6: On a located fault, `cell_hot` has only bit i set and `cell_num` equals i+1, for cell index i starting at 0. These outputs appear on the deciding sample edge and then hold through any further input until reset.
- R7: If zero bits, or two or more bits, of the relevant indicator vector are high in a decision state, `ambiguous` goes high and stays high until reset. The block returns to the same-polarity fault wait without locating.
- R8: Edges with `sample_en` low change no state and no output.
- R9: `fault_any` is high exactly when the block is not idle.
- R10: Synchronous active-high `rst` returns the block to idle, with `fault_any`, `ambiguous`, `cell_hot` and `cell_num` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Qualifies the edges on which state may change |
| err_pos | input | 1 | Sustained positive voltage error seen |
| err_neg | input | 1 | Sustained negative voltage error seen |
| err_clear | input | 1 | Error has stayed inside its band long enough |
| step_up | input | N_CELLS | Per-cell recent upward step command |
| step_dn | input | N_CELLS | Per-cell recent downward step command |
| fault_any | output | 1 | Block is outside idle |
| ambiguous | output | 1 | A decision did not single out one cell |
| cell_hot | output | N_CELLS | One-hot located cell |
| cell_num | output | CELL_W | Located cell number, 1-based, 0 when none |

## Verification
The hardest cases to reach are the decision states themselves. Each one is only entered after a fault sample and then a clear sample, and it is left again on the very next enabled edge. The bench therefore walks both polarities through error, clear and decision, and at the decision edge it applies every pattern of the three-bit indicator vector. The opposite-direction vector is loaded with misleading bits at the same time. After an ambiguous decision, a second clear followed by a valid pattern shows that the block really did go back to waiting.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_POS     = 3'd1,
        ST_NEG     = 3'd2,
        ST_POS_DEC = 3'd3,
        ST_NEG_DEC = 3'd4,
        ST_LOCK    = 3'd5
    } fcl_state_e;

    typedef struct packed {
        logic pos;
        logic neg;
        logic clear;
    } fcl_flags_t;

    function automatic logic is_decide(input fcl_state_e s);
        return (s == ST_POS_DEC) || (s == ST_NEG_DEC);
    endfunction

endpackage

// File: rtl/fcl_pick.sv
module fcl_pick #(
    parameter int N_CELLS = 3,
    parameter int CELL_W  = $clog2(N_CELLS + 1)
) (
    input  logic               use_up,
    input  logic [N_CELLS-1:0] step_up,
    input  logic [N_CELLS-1:0] step_dn,
    output logic [N_CELLS-1:0] cand,
    output logic               single,
    output logic [CELL_W-1:0]  num
);
    localparam int CNT_W = $clog2(N_CELLS + 1);

    logic [CNT_W-1:0] hits;

    assign cand = use_up ? step_up : step_dn;

    always_comb begin
        hits = '0;
        num  = '0;
        for (int i = 0; i < N_CELLS; i++) begin
            if (cand[i]) begin
                hits = hits + CNT_W'(1);
                num  = CELL_W'(i + 1);
            end
        end
    end

    assign single = (hits == CNT_W'(1));

endmodule

// File: rtl/fcl_fsm.sv
module fcl_fsm
    import fcl_pkg::*;
#(
    parameter int N_CELLS = 3,
    parameter int CELL_W  = $clog2(N_CELLS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_en,
    input  fcl_flags_t         flags,
    input  logic [N_CELLS-1:0] cand,
    input  logic               single,
    input  logic [CELL_W-1:0]  pick_num,
    output logic               use_up,
    output logic               fault_any,
    output logic               ambiguous,
    output logic [N_CELLS-1:0] cell_hot,
    output logic [CELL_W-1:0]  cell_num
);
    fcl_state_e state, state_nx;

    assign use_up    = (state == ST_NEG_DEC);
    assign fault_any = (state != ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (flags.pos) state_nx = ST_POS;
                        else if (flags.neg) state_nx = ST_NEG;
            ST_POS:     if (flags.clear) state_nx = ST_POS_DEC;
            ST_NEG:     if (flags.clear) state_nx = ST_NEG_DEC;
            ST_POS_DEC: state_nx = single ? ST_LOCK : ST_POS;
            ST_NEG_DEC: state_nx = single ? ST_LOCK : ST_NEG;
            ST_LOCK:    state_nx = ST_LOCK;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ambiguous <= 1'b0;
            cell_hot  <= '0;
            cell_num  <= '0;
        end else if (sample_en) begin
            state <= state_nx;
            if (is_decide(state)) begin
                if (single) begin
                    cell_hot <= cand;
                    cell_num <= pick_num;
                end else begin
                    ambiguous <= 1'b1;
                end
            end
        end
    end

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK) |=> (state == ST_LOCK) && $stable(cell_hot) && $stable(cell_num)); // R6
    AST_HOT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cell_hot)); // R6
    AST_NO_LOC_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        (state != ST_LOCK) |-> (cell_hot == '0) && (cell_num == '0)); // R2
    AST_GATED: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(state) && $stable(ambiguous)); // R8
    AST_POS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && sample_en && flags.pos) |=> (state == ST_POS)); // R3
    AST_AMBIG_RETURN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POS_DEC && sample_en && !single) |=> (state == ST_POS) && ambiguous); // R7

endmodule

// File: rtl/fault_cell_locator.sv
module fault_cell_locator
    import fcl_pkg::*;
#(
    parameter int N_CELLS = 3,
    parameter int CELL_W  = $clog2(N_CELLS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_en,
    input  logic               err_pos,
    input  logic               err_neg,
    input  logic               err_clear,
    input  logic [N_CELLS-1:0] step_up,
    input  logic [N_CELLS-1:0] step_dn,
    output logic               fault_any,
    output logic               ambiguous,
    output logic [N_CELLS-1:0] cell_hot,
    output logic [CELL_W-1:0]  cell_num
);
    fcl_flags_t         flags;
    logic               use_up;
    logic [N_CELLS-1:0] cand;
    logic               single;
    logic [CELL_W-1:0]  pick_num;

    assign flags = '{pos: err_pos, neg: err_neg, clear: err_clear};

    fcl_pick #(.N_CELLS(N_CELLS), .CELL_W(CELL_W)) i_pick (
        .use_up  (use_up),
        .step_up (step_up),
        .step_dn (step_dn),
        .cand    (cand),
        .single  (single),
        .num     (pick_num)
    );

    fcl_fsm #(.N_CELLS(N_CELLS), .CELL_W(CELL_W)) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .flags     (flags),
        .cand      (cand),
        .single    (single),
        .pick_num  (pick_num),
        .use_up    (use_up),
        .fault_any (fault_any),
        .ambiguous (ambiguous),
        .cell_hot  (cell_hot),
        .cell_num  (cell_num)
    );

endmodule

// File: tb/test_fault_cell_locator.sv
module test_fault_cell_locator;
    localparam int N = 3;
    localparam int W = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_en = 1'b0;
    logic err_pos = 1'b0, err_neg = 1'b0, err_clear = 1'b0;
    logic [N-1:0] step_up = '0, step_dn = '0;
    logic fault_any, ambiguous;
    logic [N-1:0] cell_hot;
    logic [W-1:0] cell_num;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fault_cell_locator #(.N_CELLS(N)) i_fault_cell_locator (
        .clk(clk), .rst(rst), .sample_en(sample_en),
        .err_pos(err_pos), .err_neg(err_neg), .err_clear(err_clear),
        .step_up(step_up), .step_dn(step_dn),
        .fault_any(fault_any), .ambiguous(ambiguous),
        .cell_hot(cell_hot), .cell_num(cell_num)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic outs(input string req, input int fa, input int am, input int hot, input int num);
        chk({req, " fault_any"}, int'(fault_any), fa);
        chk({req, " ambiguous"}, int'(ambiguous), am);
        chk({req, " cell_hot"},  int'(cell_hot), hot);
        chk({req, " cell_num"},  int'(cell_num), num);
    endtask

    // one edge; inputs driven at negedge, outputs read 1 ns after posedge
    task automatic edge1(input logic en, input logic p, input logic n, input logic c,
                         input logic [N-1:0] u, input logic [N-1:0] d);
        @(negedge clk);
        sample_en = en; err_pos = p; err_neg = n; err_clear = c; step_up = u; step_dn = d;
        @(posedge clk);
        #1;
        sample_en = 1'b0; err_pos = 1'b0; err_neg = 1'b0; err_clear = 1'b0;
        step_up = '0; step_dn = '0;
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
    endtask

    function automatic int pop(input logic [N-1:0] v);
        int k = 0;
        for (int i = 0; i < N; i++) if (v[i]) k++;
        return k;
    endfunction

    function automatic int idx1(input logic [N-1:0] v);
        int k = 0;
        for (int i = 0; i < N; i++) if (v[i]) k = i + 1;
        return k;
    endfunction

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        @(posedge clk); #1;
        outs("R10 reset", 0, 0, 0, 0);
        @(negedge clk); rst = 1'b0;

        // R8: no enable, nothing moves
        edge1(1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
        outs("R8 gated idle", 0, 0, 0, 0);
        // R1 positive entry, R9
        edge1(1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
        outs("R1 R9 pos entry", 1, 0, 0, 0);
        // R2: fault flags again, no clear -> still waiting
        edge1(1'b1, 1'b1, 1'b1, 1'b0, 3'b111, 3'b001);
        edge1(1'b1, 1'b0, 1'b0, 1'b0, '0, 3'b001);
        outs("R2 wait", 1, 0, 0, 0);
        // R8 gated clear, then gated decision would not lock
        edge1(1'b0, 1'b0, 1'b0, 1'b1, '0, '0);
        edge1(1'b1, 1'b0, 1'b0, 1'b0, '0, 3'b010);
        outs("R8 gated clear", 1, 0, 0, 0);

        // sweep both polarities over every indicator pattern
        for (int pol = 0; pol < 2; pol++) begin
            for (int pat = 0; pat < (1 << N); pat++) begin
                logic [N-1:0] good = N'(pat);
                logic [N-1:0] noise = ~good;
                do_reset();
                edge1(1'b1, pol == 0, pol == 1, 1'b0, '0, '0);
                outs(pol == 0 ? "R1 pos" : "R1 neg", 1, 0, 0, 0);
                edge1(1'b1, 1'b0, 1'b0, 1'b1, '0, '0);
                outs("R2 decide entry", 1, 0, 0, 0);
                if (pol == 0) edge1(1'b1, 1'b0, 1'b0, 1'b0, noise, good);
                else          edge1(1'b1, 1'b0, 1'b0, 1'b0, good, noise);
                if (pop(good) == 1) begin
                    outs(pol == 0 ? "R4 R6 locate" : "R5 R6 locate", 1, 0, int'(good), idx1(good));
                    // R6 hold under further activity
                    edge1(1'b1, 1'b1, 1'b1, 1'b1, 3'b111, 3'b111);
                    edge1(1'b1, 1'b0, 1'b0, 1'b1, 3'b101, 3'b010);
                    outs("R6 hold", 1, 0, int'(good), idx1(good));
                end else begin
                    outs("R7 ambiguous", 1, 1, 0, 0);
                    // back in wait: a decision edge without clear must not lock
                    edge1(1'b1, 1'b0, 1'b0, 1'b0, 3'b001, 3'b001);
                    outs("R7 back to wait", 1, 1, 0, 0);
                    edge1(1'b1, 1'b0, 1'b0, 1'b1, '0, '0);
                    edge1(1'b1, 1'b0, 1'b0, 1'b0, pol == 1 ? 3'b100 : 3'b000,
                          pol == 0 ? 3'b100 : 3'b000);
                    outs("R7 relocate", 1, 1, 4, 3);
                end
            end
        end

        // R3: both errors -> positive branch uses step_dn
        do_reset();
        outs("R10 reset again", 0, 0, 0, 0);
        edge1(1'b1, 1'b1, 1'b1, 1'b0, '0, '0);
        edge1(1'b1, 1'b0, 1'b0, 1'b1, '0, '0);
        edge1(1'b1, 1'b0, 1'b0, 1'b0, 3'b010, 3'b001);
        outs("R3 pos priority", 1, 0, 1, 1);
        // R10 reset from lock
        do_reset();
        outs("R10 reset from lock", 0, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule